// File: doc/BRIEF.md
# Repeated Multiply-Accumulate Sequencer

This block computes a long sum of products against a table of coefficients. A start pulse loads a repeat count and a starting coefficient address. The block then runs one multiply-accumulate step for each data operand it consumes. Each step reads its coefficient from an address that counts upward. An external synchronous memory returns the coefficient words.

Within a step, the accumulator first absorbs the product left by the step before, scaled by a selectable shift. The new signed product then replaces that product. The result of any multiply therefore reaches the accumulator one step later.

A repeat count of N runs N+1 steps. Around each run, the block saves and later restores its own fetch address. The accumulator and the product register keep their values from one run to the next. The caller can therefore chain runs, or collect the last pending product with a final step.

Top module: `rep_mac_seq`

## Requirements
- R1: After reset, `acc`, `prod`, `tReg` and `coefAddr` are zero, and `carry`, `ovf` and `busy` are low.
- R2: Each step first adds the current `prod`, shifted, into `acc`. It then loads `prod` with the signed 16x16 product of `dataIn` and `coefData`, and copies `dataIn` into `tReg`. For example, 0x0023 times 0xFAAA gives 0xFFFF453E.
- R3: `shiftMode` sets the scaling applied to `prod` before it is accumulated: 0 is no shift, 1 is a left shift by 1, 2 is a left shift by 4, and 3 is an arithmetic right shift by 6.
- R4: A repeat count of N gives exactly N+1 steps. Every step except the last adds one to `coefAddr` and lowers the remaining count by one. The last step runs with the count at zero and does not advance the address.
- R5: An accepted start saves the current fetch address and places `startAddr` on `coefAddr` one cycle later. `busy` rises at the same time. The last step puts the saved address back on `coefAddr` and drops `busy`.
- R6: `carry` takes the unsigned carry out of the 32-bit sum of `acc` and the sign-extended shifted product. It is updated on every step.
- R7: A signed overflow of the accumulation sets `ovf`, which then stays high until the next accepted start clears it. When `ovfMode` is 1, an overflowing result is replaced by 0x7FFFFFFF if `acc` was non-negative, or by 0x80000000 if it was negative. When `ovfMode` is 0, the sum wraps.
- R8: A `start` pulse while `busy` is high is ignored: the address sequence, the step count and the results of the run in progress are unchanged.
- R9: `coefData` is expected one cycle after the address that produced it. A step consumes `dataIn` only when `dataValid` is high and `coefAddr` has been stable for at least one cycle. A strobe in the first cycle after an address change is not consumed, so at most one step completes every two cycles.
- R10: `dataValid` while `busy` is low changes neither `acc`, `prod` nor `tReg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, ignored while busy |
| repCount | input | 8 | Repeat count N, giving N+1 steps |
| startAddr | input | 16 | First coefficient address |
| shiftMode | input | 2 | Product scaling mode |
| ovfMode | input | 1 | 1 saturates on overflow, 0 wraps |
| dataIn | input | 16 | Signed data operand |
| dataValid | input | 1 | Data operand strobe |
| coefData | input | 16 | Coefficient read data, one cycle after the address |
| coefAddr | output | 16 | Coefficient read address |
| busy | output | 1 | High from an accepted start until the last step |
| acc | output | 32 | Accumulator |
| prod | output | 32 | Product register |
| tReg | output | 16 | Last consumed data operand |
| carry | output | 1 | Carry out of the last accumulation |
| ovf | output | 1 | Sticky overflow flag |

## Verification
`coefAddr` and `busy` settle one cycle after an accepted start. After each address change, the driver presents an operand with its strobe. The first clock edge that follows only returns the coefficient, and the bench checks that `acc` has not moved yet. The second edge is the step, so `tReg`, `prod`, `acc`, the flags, the next address and `busy` are all due one cycle after it. The driver pushes the values the model predicts just after that edge, and the monitor compares them at the following falling edge.

// File: rtl/rms_pkg.sv
package rms_pkg;

  typedef enum logic [1:0] {
    SHIFT_NONE = 2'd0,
    SHIFT_L1   = 2'd1,
    SHIFT_L4   = 2'd2,
    SHIFT_R6   = 2'd3
  } shiftMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic step;      // one multiply-accumulate step this cycle
    logic clrFlags;  // accepted start: clear sticky overflow
  } rmsCtrl_t;

endpackage

// File: rtl/rms_ctrl.sv
module rms_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    repCount,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic                dataValid,
  output rms_pkg::rmsCtrl_t   ctrl,
  output logic [ADDR_W-1:0]   coefAddr,
  output logic                busy
);

  logic [ADDR_W-1:0] fetchAddr;
  logic [ADDR_W-1:0] savedAddr;
  logic [CNT_W-1:0]  repCnt;
  logic              busyR;
  logic              coefRdy;
  logic              stepNow;
  logic              lastStep;
  logic              accept;

  assign accept   = start & ~busyR;
  assign stepNow  = busyR & coefRdy & dataValid;
  assign lastStep = stepNow & (repCnt == '0);

  always_comb begin
    ctrl          = '0;
    ctrl.step     = stepNow;
    ctrl.clrFlags = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetchAddr <= '0;
      savedAddr <= '0;
      repCnt    <= '0;
      busyR     <= 1'b0;
      coefRdy   <= 1'b0;
    end else if (accept) begin
      savedAddr <= fetchAddr;
      fetchAddr <= startAddr;
      repCnt    <= repCount;
      busyR     <= 1'b1;
      coefRdy   <= 1'b0;
    end else if (stepNow) begin
      coefRdy <= 1'b0;
      if (repCnt != '0) begin
        fetchAddr <= fetchAddr + ADDR_W'(1);
        repCnt    <= repCnt - CNT_W'(1);
      end else begin
        fetchAddr <= savedAddr;
        busyR     <= 1'b0;
      end
    end else if (busyR) begin
      coefRdy <= 1'b1;
    end
  end

  assign coefAddr = fetchAddr;
  assign busy     = busyR;

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busyR) |=> (busyR && fetchAddr == $past(startAddr)));

  assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lastStep |=> (!busyR && fetchAddr == $past(savedAddr)));

  assert_incr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stepNow && repCnt != '0) |=>
      (fetchAddr == $past(fetchAddr) + ADDR_W'(1) && repCnt == $past(repCnt) - CNT_W'(1)));

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busyR && start && !stepNow) |=> ($stable(fetchAddr) && $stable(repCnt)));

  assert_step_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stepNow |=> !stepNow);

endmodule

// File: rtl/rms_datapath.sv
module rms_datapath #(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rms_pkg::rmsCtrl_t     ctrl,
  input  logic [1:0]            shiftMode,
  input  logic                  ovfMode,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic [DATA_W-1:0]     coefData,
  output logic [2*DATA_W-1:0]   acc,
  output logic [2*DATA_W-1:0]   prod,
  output logic [DATA_W-1:0]     tReg,
  output logic                  carry,
  output logic                  ovf
);
  import rms_pkg::*;

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0]        addend;
  logic [PROD_W:0]          sumWide;
  logic [PROD_W-1:0]        sumW;
  logic                     ovfNow;
  logic [PROD_W-1:0]        satVal;
  logic [PROD_W-1:0]        accNext;
  logic signed [PROD_W-1:0] dataS;
  logic signed [PROD_W-1:0] coefS;
  logic signed [PROD_W-1:0] mulRes;

  always_comb begin
    case (shiftMode_e'(shiftMode))
      SHIFT_NONE: addend = prod;
      SHIFT_L1:   addend = prod << 1;
      SHIFT_L4:   addend = prod << 4;
      default:    addend = $signed(prod) >>> 6;
    endcase
  end

  assign sumWide = {1'b0, acc} + {1'b0, addend};
  assign sumW    = sumWide[PROD_W-1:0];
  assign ovfNow  = (acc[PROD_W-1] == addend[PROD_W-1]) && (sumW[PROD_W-1] != acc[PROD_W-1]);
  assign satVal  = acc[PROD_W-1] ? {1'b1, {(PROD_W-1){1'b0}}} : {1'b0, {(PROD_W-1){1'b1}}};
  assign accNext = (ovfNow && ovfMode) ? satVal : sumW;

  assign dataS  = PROD_W'($signed(dataIn));
  assign coefS  = PROD_W'($signed(coefData));
  assign mulRes = dataS * coefS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      prod  <= '0;
      tReg  <= '0;
      carry <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (ctrl.step) begin
        acc   <= accNext;
        prod  <= mulRes;
        tReg  <= dataIn;
        carry <= sumWide[PROD_W];
      end
      if (ctrl.clrFlags)
        ovf <= 1'b0;
      else if (ctrl.step && ovfNow)
        ovf <= 1'b1;
    end
  end

  assert_treg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.step |=> (tReg == $past(dataIn)));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ctrl.clrFlags) |=> ovf);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.step |=> ($stable(acc) && $stable(prod) && $stable(tReg)));

endmodule

// File: rtl/rep_mac_seq.sv
module rep_mac_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     repCount,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [1:0]           shiftMode,
  input  logic                 ovfMode,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 dataValid,
  input  logic [DATA_W-1:0]    coefData,
  output logic [ADDR_W-1:0]    coefAddr,
  output logic                 busy,
  output logic [2*DATA_W-1:0]  acc,
  output logic [2*DATA_W-1:0]  prod,
  output logic [DATA_W-1:0]    tReg,
  output logic                 carry,
  output logic                 ovf
);

  rms_pkg::rmsCtrl_t ctrl;

  rms_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .repCount  (repCount),
    .startAddr (startAddr),
    .dataValid (dataValid),
    .ctrl      (ctrl),
    .coefAddr  (coefAddr),
    .busy      (busy)
  );

  rms_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .shiftMode (shiftMode),
    .ovfMode   (ovfMode),
    .dataIn    (dataIn),
    .coefData  (coefData),
    .acc       (acc),
    .prod      (prod),
    .tReg      (tReg),
    .carry     (carry),
    .ovf       (ovf)
  );

endmodule

// File: tb/rep_mac_seq_tb_top.sv
module rep_mac_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  repCount = '0;
  logic [15:0] startAddr = '0;
  logic [1:0]  shiftMode = '0;
  logic        ovfMode = 1'b0;
  logic [15:0] dataIn = '0;
  logic        dataValid = 1'b0;
  logic [15:0] coefData = '0;
  logic [15:0] coefAddr;
  logic        busy;
  logic [31:0] acc;
  logic [31:0] prod;
  logic [15:0] tReg;
  logic        carry;
  logic        ovf;

  int nChecks = 0;
  int nErr = 0;

  rep_mac_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .repCount(repCount),
    .startAddr(startAddr), .shiftMode(shiftMode), .ovfMode(ovfMode),
    .dataIn(dataIn), .dataValid(dataValid), .coefData(coefData),
    .coefAddr(coefAddr), .busy(busy), .acc(acc), .prod(prod),
    .tReg(tReg), .carry(carry), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // computed coefficient memory, synchronous read
  function automatic logic [15:0] coefOf(input logic [15:0] a);
    if (a[15:12] == 4'hF) return 16'hFAAA;
    if (a[15])            return 16'h7FFF;
    return a * 16'd73 + 16'h1234;
  endfunction

  always @(posedge clk) coefData <= coefOf(coefAddr);

  // reference model
  logic [31:0] mAcc, mProd;
  logic [15:0] mT;
  logic        mCarry, mOvf;

  typedef struct {
    logic [15:0] t;
    logic [31:0] p;
    logic [31:0] a;
    logic        c;
    logic        o;
    logic [15:0] addr;
    logic        bz;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic modelReset();
    mAcc = '0; mProd = '0; mT = '0; mCarry = 1'b0; mOvf = 1'b0;
  endtask

  task automatic modelStep(input logic [15:0] d, input logic [15:0] c);
    logic [31:0] add;
    logic [32:0] s;
    logic        ov;
    logic signed [31:0] ds, cs;
    case (shiftMode)
      2'd0: add = mProd;
      2'd1: add = mProd << 1;
      2'd2: add = mProd << 4;
      default: add = $signed(mProd) >>> 6;
    endcase
    s  = {1'b0, mAcc} + {1'b0, add};
    ov = (mAcc[31] == add[31]) && (s[31] != mAcc[31]);
    mCarry = s[32];
    if (ov) mOvf = 1'b1;
    if (ov && ovfMode) mAcc = mAcc[31] ? 32'h80000000 : 32'h7FFFFFFF;
    else mAcc = s[31:0];
    ds = $signed(d);
    cs = $signed(c);
    mProd = ds * cs;
    mT = d;
  endtask

  // monitor: compare results one cycle after each step
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " R2 tReg"}, {16'h0, tReg}, {16'h0, e.t});
      check({e.tag, " R2 prod"}, prod, e.p);
      check({e.tag, " R3 acc"}, acc, e.a);
      check({e.tag, " R6 carry"}, {31'h0, carry}, {31'h0, e.c});
      check({e.tag, " R7 ovf"}, {31'h0, ovf}, {31'h0, e.o});
      check({e.tag, " R4 coefAddr"}, {16'h0, coefAddr}, {16'h0, e.addr});
      check({e.tag, " R5 busy"}, {31'h0, busy}, {31'h0, e.bz});
    end
  end

  task automatic doReset();
    rst_n = 1'b0;
    start = 1'b0;
    dataValid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    modelReset();
    @(negedge clk);
    check("R1 acc", acc, 32'h0);
    check("R1 prod", prod, 32'h0);
    check("R1 tReg/coefAddr", {tReg, coefAddr}, 32'h0);
    check("R1 flags", {29'h0, carry, ovf, busy}, 32'h0);
  endtask

  task automatic runOp(input logic [7:0] cnt, input logic [15:0] sAddr,
                       input logic [1:0] sm, input logic om,
                       input logic [15:0] seed, input logic [15:0] stride,
                       input bit pokeStart, input string tag);
    @(negedge clk);
    shiftMode = sm;
    ovfMode   = om;
    repCount  = cnt;
    startAddr = sAddr;
    start     = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    mOvf = 1'b0;
    check({tag, " R5 start addr"}, {15'h0, busy, coefAddr}, {15'h0, 1'b1, sAddr});
    for (int i = 0; i <= int'(cnt); i++) begin
      logic [15:0] d;
      logic [15:0] a;
      d = seed + 16'(i) * stride;
      a = sAddr + 16'(i);
      dataIn = d;
      dataValid = 1'b1;
      if (pokeStart && i == 1) begin
        start = 1'b1;
        startAddr = sAddr + 16'h0100;
        repCount = 8'd0;
      end
      @(posedge clk);
      #1;
      // R9: the strobe in the cycle after an address change is not consumed
      check({tag, " R9 no step before coefficient"}, acc, mAcc);
      @(posedge clk);
      #1 start = 1'b0;
      modelStep(d, coefOf(a));
      begin
        exp_t e;
        e.t = mT; e.p = mProd; e.a = mAcc; e.c = mCarry; e.o = mOvf;
        e.addr = (i == int'(cnt)) ? 16'h0000 : a + 16'h1;
        e.bz = (i != int'(cnt));
        e.tag = tag;
        sb.push_back(e);
      end
    end
    dataValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    doReset();

    // R4: count 0 gives a single step, address restored
    runOp(8'd0, 16'h0010, 2'd0, 1'b0, 16'h0005, 16'h0, 1'b0, "single R4");
    // R2: products reach the accumulator one step late
    runOp(8'd3, 16'h0020, 2'd0, 1'b0, 16'hFF80, 16'h0123, 1'b0, "late R2");
    // R2 example product 0x23 * 0xFAAA
    runOp(8'd0, 16'hF000, 2'd3, 1'b0, 16'h0023, 16'h0, 1'b0, "example R2");
    check("R2 example product", prod, 32'hFFFF453E);
    // R3: each shift mode
    runOp(8'd4, 16'h0040, 2'd3, 1'b0, 16'h1357, 16'h0F0F, 1'b0, "mode3 R3");
    runOp(8'd4, 16'h0050, 2'd1, 1'b0, 16'h8001, 16'h0777, 1'b0, "mode1 R3");
    runOp(8'd4, 16'h0060, 2'd2, 1'b0, 16'h0033, 16'h0101, 1'b0, "mode2 R3");
    // R8: start pulse during a run is ignored
    runOp(8'd5, 16'h0070, 2'd0, 1'b0, 16'h2222, 16'h0345, 1'b1, "poke R8");
    // R4: 255 gives 256 steps
    runOp(8'd255, 16'h0100, 2'd1, 1'b0, 16'h0101, 16'h0011, 1'b0, "long R4");
    check("R4 idle after 256 steps", {31'h0, busy}, 32'h0);

    // R10: strobe while idle has no effect
    @(negedge clk);
    dataIn = 16'h5A5A;
    dataValid = 1'b1;
    repeat (3) @(posedge clk);
    #1 dataValid = 1'b0;
    check("R10 acc held", acc, mAcc);
    check("R10 prod held", prod, mProd);
    check("R10 tReg held", {16'h0, tReg}, {16'h0, mT});

    // R7: wrap on positive overflow
    doReset();
    runOp(8'd5, 16'h8000, 2'd1, 1'b0, 16'h7FFF, 16'h0, 1'b0, "wrap R7");
    check("R7 wrap ovf set", {31'h0, ovf}, 32'h1);

    // R7: saturate positive
    doReset();
    runOp(8'd5, 16'h8000, 2'd1, 1'b1, 16'h7FFF, 16'h0, 1'b0, "satpos R7");
    check("R7 saturate positive", acc, 32'h7FFFFFFF);

    // R7: saturate negative
    doReset();
    runOp(8'd5, 16'h8000, 2'd1, 1'b1, 16'h8000, 16'h0, 1'b0, "satneg R7");
    check("R7 saturate negative", acc, 32'h80000000);
    // following run starts with flag cleared (model tracks the result)
    runOp(8'd2, 16'h0200, 2'd3, 1'b0, 16'h0001, 16'h0001, 1'b0, "clear R7");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule